// File: doc/BRIEF.md
# Pair-Granular Fetch-to-Dispatch Instruction Queue

This block sits between instruction fetch and a four-wide dispatch stage. Each cycle fetch may hand over a group of up to two instructions, which the queue stores together as one pair. The two oldest pairs are always shown to dispatch as four slots, each with a valid bit. Dispatch reports how many of the oldest offered instructions it took. When dispatch falls behind, instructions stay in the queue.

Storage is four pair slots, eight instructions in total. Instructions leave one at a time, in age order. A pair slot is freed only once nothing valid remains in it. Compaction moves whole pairs toward the head, so the shift network only needs pair-sized steps of zero, one or two positions. A flush empties the queue in a single cycle.

Top module: `pair_fetch_buffer`

## Requirements
- R1: After reset every dispatch valid bit is 0 and fetch_ready_o is 1.
- R2: The queue holds at most four pairs (eight instructions). fetch_ready_o is 0 exactly when all four pair slots are occupied at the start of the cycle.
- R3: When fetch_ready_o is 1, flush_i is 0 and fetch_valid_i is nonzero, the group is stored as one pair that keeps its lane valid bits. Fetch lane 0 (bits INSTR_W-1:0) is older than lane 1. A group offered while fetch_ready_o is 0 is dropped and changes nothing.
- R4: Dispatch slots 0 and 1 show lanes 0 and 1 of the head pair. Slots 2 and 3 show lanes 0 and 1 of the next pair. Each valid bit is the stored lane valid, and slot order is age order.
- R5: disp_take_i = N removes, at the next edge, the N lowest-numbered valid dispatch slots. With N = 0 and no accepted fetch the outputs do not change. An N larger than the number of valid slots removes all of them.
- R6: A pair slot is released only when none of its lanes remain valid. A partly consumed head pair stays at the head with its remaining instruction in its original lane.
- R7: Released pairs are squeezed out in the same update. The surviving pairs move toward the head and keep their relative order.
- R8: flush_i clears every entry at the next edge. Any fetch group offered in that cycle is dropped.
- R9: In a cycle with both an accepted fetch and a dispatch, the new pair is placed behind all surviving pairs. Acceptance depends only on occupancy at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all held instructions |
| fetch_valid_i | input | 2 | Per-lane valid of the fetch group |
| fetch_instr_i | input | 2*INSTR_W | Fetch group, lane 0 in the low bits |
| fetch_ready_o | output | 1 | A free pair slot is available this cycle |
| disp_valid_o | output | 4 | Per-slot valid of the dispatch window |
| disp_instr_o | output | 4*INSTR_W | Dispatch window, slot 0 in the low bits |
| disp_take_i | input | 3 | Number of oldest valid slots dispatch consumed |

## Verification
Any wrong occupancy, valid bit or shift amount shows up at the ports one cycle after the faulty update. It appears either as a wrong valid pattern or instruction in the four-slot window, or as fetch_ready_o changing at the wrong occupancy. A dropped or duplicated pair may stay hidden behind the window for up to two further pair removals, so the bench keeps draining the queue and compares every valid slot in every cycle.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned PAIR_LANES = 2;

  function automatic int unsigned lanes_set(input logic [PAIR_LANES-1:0] v);
    int unsigned n;
    n = 0;
    for (int l = 0; l < PAIR_LANES; l++) n += 32'(v[l]);
    return n;
  endfunction
endpackage

// File: rtl/pfb_take_mask.sv
module pfb_take_mask #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic [SLOTS-1:0] vld_i,
  input  logic [CNT_W-1:0] take_i,
  output logic [SLOTS-1:0] taken_o
);
  always_comb begin
    int seen;
    seen = 0;
    for (int s = 0; s < SLOTS; s++) begin
      taken_o[s] = vld_i[s] && (seen < int'(take_i));
      if (vld_i[s]) seen++;
    end
  end
endmodule

// File: rtl/pfb_release.sv
module pfb_release #(
  parameter int unsigned DISP_PAIRS = 2,
  parameter int unsigned OCC_W      = 3
) (
  input  logic [2*DISP_PAIRS-1:0] vld_left_i,
  input  logic [OCC_W-1:0]        occ_i,
  output logic [OCC_W-1:0]        rel_o
);
  always_comb begin
    logic run;
    int   rel;
    run = 1'b1;
    rel = 0;
    // only a contiguous run of empty pairs from the head may go
    for (int p = 0; p < DISP_PAIRS; p++) begin
      if (run && (p < int'(occ_i)) && (vld_left_i[2*p +: 2] == 2'b00)) rel++;
      else run = 1'b0;
    end
    rel_o = OCC_W'(rel);
  end
endmodule

// File: rtl/pair_fetch_buffer.sv
module pair_fetch_buffer #(
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned NUM_PAIRS  = 4,
  parameter int unsigned DISP_PAIRS = 2,
  localparam int unsigned LANES     = pfb_pkg::PAIR_LANES,
  localparam int unsigned DISP_W    = DISP_PAIRS * LANES,
  localparam int unsigned CNT_W     = $clog2(DISP_W + 1),
  localparam int unsigned OCC_W     = $clog2(NUM_PAIRS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic [LANES-1:0]           fetch_valid_i,
  input  logic [LANES*INSTR_W-1:0]   fetch_instr_i,
  output logic                       fetch_ready_o,
  output logic [DISP_W-1:0]          disp_valid_o,
  output logic [DISP_W*INSTR_W-1:0]  disp_instr_o,
  input  logic [CNT_W-1:0]           disp_take_i
);
  logic [LANES-1:0]   vld_q [NUM_PAIRS];
  logic [LANES-1:0]   vld_n [NUM_PAIRS];
  logic [LANES-1:0]   vld_u [NUM_PAIRS];
  logic [INSTR_W-1:0] dat_q [NUM_PAIRS][LANES];
  logic [INSTR_W-1:0] dat_n [NUM_PAIRS][LANES];
  logic [OCC_W-1:0]   occ_q, occ_n, rel;
  logic [DISP_W-1:0]  win_vld, taken;
  logic               accept;

  assign fetch_ready_o = (occ_q != OCC_W'(NUM_PAIRS));
  assign accept        = fetch_ready_o && (|fetch_valid_i) && !flush_i;

  for (genvar p = 0; p < DISP_PAIRS; p++) begin : g_win
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign win_vld[p*LANES+l] = vld_q[p][l];
      assign disp_instr_o[(p*LANES+l)*INSTR_W +: INSTR_W] = dat_q[p][l];
    end
  end
  assign disp_valid_o = win_vld;

  pfb_take_mask #(.SLOTS(DISP_W), .CNT_W(CNT_W)) take_i_u (
    .vld_i(win_vld), .take_i(disp_take_i), .taken_o(taken)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_upd
    if (p < DISP_PAIRS) begin : g_in_win
      assign vld_u[p] = vld_q[p] & ~taken[p*LANES +: LANES];
    end else begin : g_out_win
      assign vld_u[p] = vld_q[p];
    end
  end

  logic [DISP_W-1:0] win_left;
  for (genvar p = 0; p < DISP_PAIRS; p++) begin : g_left
    assign win_left[p*LANES +: LANES] = vld_u[p];
  end

  pfb_release #(.DISP_PAIRS(DISP_PAIRS), .OCC_W(OCC_W)) rel_u (
    .vld_left_i(win_left), .occ_i(occ_q), .rel_o(rel)
  );

  always_comb begin
    int occ_i, rel_i, ins;
    occ_i = int'(occ_q);
    rel_i = int'(rel);
    ins   = occ_i - rel_i;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      vld_n[i] = '0;
      for (int l = 0; l < LANES; l++) dat_n[i][l] = dat_q[i][l];
      for (int s = 0; s < NUM_PAIRS; s++) begin
        if (s == i + rel_i && s < occ_i) begin
          vld_n[i] = vld_u[s];
          for (int l = 0; l < LANES; l++) dat_n[i][l] = dat_q[s][l];
        end
      end
      if (accept && i == ins) begin
        vld_n[i] = fetch_valid_i;
        for (int l = 0; l < LANES; l++) dat_n[i][l] = fetch_instr_i[l*INSTR_W +: INSTR_W];
      end
    end
    occ_n = OCC_W'(ins + (accept ? 1 : 0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      for (int i = 0; i < NUM_PAIRS; i++) begin
        vld_q[i] <= '0;
        for (int l = 0; l < LANES; l++) dat_q[i][l] <= '0;
      end
    end else if (flush_i) begin
      occ_q <= '0;
      for (int i = 0; i < NUM_PAIRS; i++) vld_q[i] <= '0;
    end else begin
      occ_q <= occ_n;
      for (int i = 0; i < NUM_PAIRS; i++) begin
        vld_q[i] <= vld_n[i];
        for (int l = 0; l < LANES; l++) dat_q[i][l] <= dat_n[i][l];
      end
    end
  end
endmodule

// File: rtl/pair_fetch_buffer_chk.sv
module pair_fetch_buffer_chk #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned DW      = 4,
  parameter int unsigned CW      = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  flush_i,
  input logic [1:0]            fetch_valid_i,
  input logic                  fetch_ready_o,
  input logic [DW-1:0]         disp_valid_o,
  input logic [DW*INSTR_W-1:0] disp_instr_o,
  input logic [CW-1:0]         disp_take_i
);
  // R8
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (disp_valid_o == '0) && fetch_ready_o);
  // R2
  full_has_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_ready_o |-> (disp_valid_o[3:2] != 2'b00));
  // R4
  head_before_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o[3:2] != 2'b00) |-> (disp_valid_o[1:0] != 2'b00));
  // R3
  accept_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_ready_o && (|fetch_valid_i) && !flush_i) |=> (disp_valid_o != '0));
  // R5
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && disp_take_i == '0 && !(fetch_ready_o && (|fetch_valid_i)))
    |=> ($stable(disp_valid_o) && $stable(disp_instr_o)));
  // R6
  partial_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && disp_valid_o[1:0] == 2'b11 && disp_take_i == CW'(1))
    |=> (disp_valid_o[1:0] == 2'b10));
endmodule

bind pair_fetch_buffer pair_fetch_buffer_chk #(
  .INSTR_W(INSTR_W), .DW(DISP_W), .CW(CNT_W)
) chk_u (.*);

// File: tb/pair_fetch_buffer_tb_top.sv
module pair_fetch_buffer_tb_top;
  localparam int W = 32;
  logic clk_i = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic [1:0] fetch_valid_i = '0;
  logic [2*W-1:0] fetch_instr_i = '0;
  logic fetch_ready_o;
  logic [3:0] disp_valid_o;
  logic [4*W-1:0] disp_instr_o;
  logic [2:0] disp_take_i = '0;

  int checks = 0, failures = 0, seq = 1;
  logic [1:0] mv [4];
  logic [W-1:0] md [4][2];
  int mocc = 0;

  always #2 clk_i = ~clk_i;

  pair_fetch_buffer dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_valid();
    return {mv[1], mv[0]};
  endfunction

  task automatic model_step(input logic [1:0] fv, input logic [W-1:0] d0, input logic [W-1:0] d1,
                            input int take, input bit fl);
    bit acc;
    int n;
    if (fl) begin
      for (int i = 0; i < 4; i++) mv[i] = '0;
      mocc = 0;
      return;
    end
    acc = (mocc < 4) && (fv != 2'b00);
    n = take;
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < 2; l++)
        if (mv[p][l] && n > 0) begin mv[p][l] = 1'b0; n--; end
    while (mocc > 0 && mv[0] == 2'b00) begin
      for (int i = 0; i < 3; i++) begin mv[i] = mv[i+1]; md[i] = md[i+1]; end
      mv[3] = '0;
      mocc--;
    end
    if (acc) begin
      mv[mocc] = fv; md[mocc][0] = d0; md[mocc][1] = d1;
      mocc++;
    end
  endtask

  task automatic compare(input string tag);
    logic [3:0] ev;
    ev = exp_valid();
    chk(fetch_ready_o == (mocc < 4), {"R2 ready ", tag}, fetch_ready_o, mocc < 4);
    chk(disp_valid_o == ev, {"R4 valid ", tag}, disp_valid_o, ev);
    for (int s = 0; s < 4; s++)
      if (ev[s]) chk(disp_instr_o[s*W +: W] == md[s/2][s%2], {"R7 data ", tag},
                     disp_instr_o[s*W +: W], md[s/2][s%2]);
  endtask

  task automatic step(input logic [1:0] fv, input int take, input bit fl, input string tag);
    logic [W-1:0] d0, d1;
    d0 = W'(seq); d1 = W'(seq + 1); seq += 2;
    fetch_valid_i = fv; fetch_instr_i = {d1, d0};
    disp_take_i = 3'(take); flush_i = fl;
    @(posedge clk_i);
    model_step(fv, d0, d1, take, fl);
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = '0; md[i][0] = '0; md[i][1] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(disp_valid_o == 4'b0000, "R1 reset valid", disp_valid_o, 0);
    chk(fetch_ready_o == 1'b1, "R1 reset ready", fetch_ready_o, 1);
    // R2 fill to capacity
    for (int i = 0; i < 4; i++) step(2'b11, 0, 0, "R3 fill");
    chk(fetch_ready_o == 1'b0, "R2 full stall", fetch_ready_o, 0);
    // R3 dropped while full
    step(2'b11, 0, 0, "R3 drop");
    chk(disp_instr_o[W-1:0] == W'(1), "R3 drop head", disp_instr_o[W-1:0], 1);
    // R6 partial head
    step(2'b00, 1, 0, "R6 partial");
    chk(disp_valid_o == 4'b1110, "R6 head lane1", disp_valid_o, 4'b1110);
    // R7 two pairs released together
    step(2'b00, 3, 0, "R7 compact");
    chk(disp_instr_o[W-1:0] == W'(5), "R7 shifted head", disp_instr_o[W-1:0], 5);
    // R9 full with dispatch: not accepted this cycle
    step(2'b11, 0, 0, "R9 refill");
    step(2'b11, 0, 0, "R9 refill2");
    chk(fetch_ready_o == 1'b0, "R9 full again", fetch_ready_o, 0);
    step(2'b11, 4, 0, "R9 take full");
    chk(fetch_ready_o == 1'b1, "R9 freed", fetch_ready_o, 1);
    // R5 overtake, single-lane pairs
    step(2'b00, 0, 1, "R8 flush");
    step(2'b01, 0, 0, "R5 single");
    step(2'b00, 4, 0, "R5 overtake");
    chk(disp_valid_o == 4'b0000, "R5 overtake empty", disp_valid_o, 0);
    // R8 flush with fetch
    step(2'b11, 0, 0, "R8 pre");
    step(2'b11, 0, 1, "R8 flush fetch");
    chk(disp_valid_o == 4'b0000, "R8 flushed", disp_valid_o, 0);
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] fv;
      fv = 2'($urandom_range(0, 3));
      step(fv, int'($urandom_range(0, 4)), ($urandom_range(0, 63) == 0), "rand");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule